// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a clocked host and a 2048 x 8 asynchronous static RAM. It accepts one read or write at a time through a request/ready handshake. It turns each request into a sequence of active-low chip-select, write-enable and output-enable strobes. Every interval in that sequence is a whole number of system clock cycles, so the same block fits any speed grade of memory once the counts are chosen. The counts are derived from the memory's nanosecond figures divided by the clock period and rounded up.

A read lowers chip select and output enable together with the new address. It waits the access count, captures the memory's data pins on the last edge and returns them with a one-cycle valid pulse. A write follows a fixed sequence:
- The address is presented with chip select low and write enable high for a setup count.
- Write enable goes low and the controller drives the data pins for the pulse count. The pulse count is the larger of the minimum pulse and the data overlap time.
- Write enable rises, and the bus is released on that same edge.
- Chip select stays low for a recovery count.

Output enable is high for the whole write. Between accesses chip select is high, so the memory sits in standby with its pins released. The address only ever moves during those idle cycles.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, memCsN, memWeN and memOeN are 1, memDqOe is 0, reqReady is 1 and rspValid is 0.
- R2: A read accepted on an edge (reqValid=1, reqWrite=0, reqReady=1) holds memCsN=0, memOeN=0, memWeN=1 and memDqOe=0 for exactly ACC_CYC cycles. On the edge that ends those cycles, memDqIn is captured into rspData. rspValid is 1 for exactly the one cycle that follows.
- R3: memAddr changes only while memCsN is 1, and never while memCsN and memWeN are both 0. In a write, memWeN falls only after SETUP_CYC cycles with memCsN=0 and the address already presented. reqReady is 0 during an access.
- R4: Whenever reqReady is 1 the controller is idle and memCsN is 1. Every access ends with at least one idle cycle.
- R5: memOeN is 1 in every cycle of a write.
- R6: memDqOe is 1 exactly in the cycles where memWeN is 0. The bus is released on the edge that raises memWeN.
- R7: In a write, memWeN stays 0 for max(PULSE_CYC, OVERLAP_CYC) cycles. memCsN then stays 0 for RECOV_CYC more cycles, for a total low time of SETUP_CYC + pulse + RECOV_CYC.
- R8: A byte written to an address is returned by a later read of that address, for all 2048 addresses and under mixed random traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 11 | Word address |
| reqWdata | input | 8 | Write data |
| reqReady | output | 1 | Controller idle, request accepted on this edge |
| rspData | output | 8 | Read data |
| rspValid | output | 1 | One-cycle pulse, rspData valid |
| memAddr | output | 11 | Memory address pins |
| memCsN | output | 1 | Chip select, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memDqOut | output | 8 | Value driven onto the data pins |
| memDqOe | output | 1 | Drive enable for the data pins |
| memDqIn | input | 8 | Value seen on the data pins |

## Verification
The bench uses a memory model that returns the inverse of the stored byte until the access count has elapsed. It also flags an address that moves under an active write, and any clash between its own drivers and the controller's. The main function is tried with two full sweeps of all 2048 addresses. The first sweep writes a pattern derived from the address and the second writes its inverse, so stuck bits and aliased address lines show up as mismatches. A long stream of random mixed reads and writes then exercises back-to-back turnarounds between write and read. The bench uses a setup count and an overlap count above their minimums, so a pulse that ignores the overlap, or a setup that is skipped, gives a wrong strobe count on every write.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WRECOV
  } ctrlState_e;

  // strobe set the control hands to the datapath, registered there
  typedef struct packed {
    logic csN;
    logic weN;
    logic oeN;
    logic dqOe;
    logic ready;
  } strobes_t;

  localparam strobes_t STB_IDLE = '{csN: 1'b1, weN: 1'b1, oeN: 1'b1, dqOe: 1'b0, ready: 1'b1};

  function automatic strobes_t stbFor(ctrlState_e s);
    strobes_t r;
    r = STB_IDLE;
    unique case (s)
      ST_IDLE:   r = STB_IDLE;
      ST_READ:   r = '{csN: 1'b0, weN: 1'b1, oeN: 1'b0, dqOe: 1'b0, ready: 1'b0};
      ST_WSETUP: r = '{csN: 1'b0, weN: 1'b1, oeN: 1'b1, dqOe: 1'b0, ready: 1'b0};
      ST_WPULSE: r = '{csN: 1'b0, weN: 1'b0, oeN: 1'b1, dqOe: 1'b1, ready: 1'b0};
      ST_WRECOV: r = '{csN: 1'b0, weN: 1'b1, oeN: 1'b1, dqOe: 1'b0, ready: 1'b0};
      default:   r = STB_IDLE;
    endcase
    return r;
  endfunction

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int ACC_CYC   = 4,
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 2,
  parameter int RECOV_CYC = 1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  output strobes_t stbNext,
  output logic     loadReq,
  output logic     captureRd
);

  localparam int LONGEST = maxOf(maxOf(ACC_CYC, SETUP_CYC), maxOf(WE_CYC, RECOV_CYC));
  localparam int CNT_W   = (LONGEST < 2) ? 1 : $clog2(LONGEST);
  localparam logic [CNT_W-1:0] ACC_LAST   = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] WE_LAST    = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] RECOV_LAST = CNT_W'(RECOV_CYC - 1);

  ctrlState_e stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic accept;

  assign accept = reqValid && (stateQ == ST_IDLE);

  always_comb begin
    stateD    = stateQ;
    cntD      = cntQ + 1'b1;
    captureRd = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        cntD = '0;
        if (accept) stateD = reqWrite ? ST_WSETUP : ST_READ;
      end
      ST_READ: begin
        if (cntQ == ACC_LAST) begin
          stateD    = ST_IDLE;
          captureRd = 1'b1;
          cntD      = '0;
        end
      end
      ST_WSETUP: begin
        if (cntQ == SETUP_LAST) begin
          stateD = ST_WPULSE;
          cntD   = '0;
        end
      end
      ST_WPULSE: begin
        if (cntQ == WE_LAST) begin
          stateD = ST_WRECOV;
          cntD   = '0;
        end
      end
      ST_WRECOV: begin
        if (cntQ == RECOV_LAST) begin
          stateD = ST_IDLE;
          cntD   = '0;
        end
      end
      default: begin
        stateD = ST_IDLE;
        cntD   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  assign loadReq = accept;
  assign stbNext = stbFor(stateD);

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stbNext,
  input  logic              loadReq,
  input  logic              captureRd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output strobes_t          stbQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic [DATA_W-1:0] wdataQ,
  output logic [DATA_W-1:0] rdataQ,
  output logic              rspValidQ
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stbQ      <= STB_IDLE;
      addrQ     <= '0;
      wdataQ    <= '0;
      rdataQ    <= '0;
      rspValidQ <= 1'b0;
    end else begin
      stbQ      <= stbNext;
      rspValidQ <= captureRd;
      if (loadReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (captureRd) rdataQ <= memDqIn;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int ACC_CYC     = 4,
  parameter int SETUP_CYC   = 1,
  parameter int PULSE_CYC   = 2,
  parameter int OVERLAP_CYC = 2,
  parameter int RECOV_CYC   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic [DATA_W-1:0] rspData,
  output logic              rspValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int WE_CYC = maxOf(PULSE_CYC, OVERLAP_CYC);

  if (ACC_CYC < 1 || SETUP_CYC < 1 || WE_CYC < 1 || RECOV_CYC < 1) begin : gBadTiming
    $error("sram_ctrl: every timing count must be at least one cycle");
  end

  strobes_t stbNext, stbQ;
  logic loadReq, captureRd;

  sram_ctrl_seq #(
    .ACC_CYC  (ACC_CYC),
    .SETUP_CYC(SETUP_CYC),
    .WE_CYC   (WE_CYC),
    .RECOV_CYC(RECOV_CYC)
  ) u_seq (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .stbNext  (stbNext),
    .loadReq  (loadReq),
    .captureRd(captureRd)
  );

  sram_ctrl_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stbNext  (stbNext),
    .loadReq  (loadReq),
    .captureRd(captureRd),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memDqIn  (memDqIn),
    .stbQ     (stbQ),
    .addrQ    (memAddr),
    .wdataQ   (memDqOut),
    .rdataQ   (rspData),
    .rspValidQ(rspValid)
  );

  assign memCsN   = stbQ.csN;
  assign memWeN   = stbQ.weN;
  assign memOeN   = stbQ.oeN;
  assign memDqOe  = stbQ.dqOe;
  assign reqReady = stbQ.ready;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [DATA_W-1:0] reqWdata,
  input logic              reqReady,
  input logic [DATA_W-1:0] rspData,
  input logic              rspValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCsN,
  input logic              memWeN,
  input logic              memOeN,
  input logic [DATA_W-1:0] memDqOut,
  input logic              memDqOe,
  input logic [DATA_W-1:0] memDqIn
);

  assert_addr_hold_in_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && !memWeN) |=> (memCsN || memWeN || $stable(memAddr)));

  assert_addr_moves_deselected_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && $past(!memCsN)) |-> $stable(memAddr));

  assert_we_after_select_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> $past(!memCsN));

  assert_idle_deselect_R4: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> memCsN);

  assert_oe_high_in_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN);

  assert_drive_in_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (!memWeN && !memCsN));

  assert_release_with_we_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> !memDqOe);

  assert_rsp_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_rsp_after_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspValid) |-> ($past(!memOeN) && memCsN));

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;

  localparam int AW = 11;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int ACC = 4;
  localparam int SETUP = 2;
  localparam int PULSE = 2;
  localparam int OVERLAP = 3;
  localparam int RECOV = 1;
  localparam int WEC = (PULSE > OVERLAP) ? PULSE : OVERLAP;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqReady, rspValid, memCsN, memWeN, memOeN, memDqOe;
  logic [DW-1:0] rspData, memDqOut, memDqIn;
  logic [AW-1:0] memAddr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sram_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .ACC_CYC(ACC), .SETUP_CYC(SETUP),
    .PULSE_CYC(PULSE), .OVERLAP_CYC(OVERLAP), .RECOV_CYC(RECOV)
  ) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspData(rspData), .rspValid(rspValid), .memAddr(memAddr),
    .memCsN(memCsN), .memWeN(memWeN), .memOeN(memOeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // behavioural memory: data valid only after ACC cycles of stable read
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] refMem [DEPTH];
  logic prevWr = 1'b0, prevRd = 1'b0;
  logic [AW-1:0] prevAddr = '0;
  int age = 0;
  int addrViol = 0, clash = 0, undriven = 0;
  logic wrAct, rdAct;

  assign wrAct = !memCsN && !memWeN;
  assign rdAct = !memCsN && memWeN && !memOeN;

  always_comb begin
    if (rdAct) memDqIn = (age >= ACC - 1) ? mem[memAddr] : ~mem[memAddr];
    else if (memDqOe) memDqIn = memDqOut;
    else memDqIn = 8'h5A;
  end

  always @(posedge clk) begin
    if (rstN) begin
      if (wrAct && prevWr && memAddr != prevAddr) addrViol <= addrViol + 1;
      if (memDqOe && rdAct) clash <= clash + 1;
      if (wrAct) begin
        if (memDqOe) mem[memAddr] <= memDqOut;
        else undriven <= undriven + 1;
      end
      if (rdAct) age <= (prevRd && memAddr == prevAddr) ? age + 1 : 1;
      else age <= 0;
      prevWr <= wrAct;
      prevRd <= rdAct;
      prevAddr <= memAddr;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int csLow = 0, weLow = 0, firstWe = -1, oeBad = 0, dqBad = 0, busyBad = 0, addrBad = 0;
    @(negedge clk);
    chk(reqReady == 1'b1 && memCsN == 1'b1, "R4 idle before write", int'(reqReady), 1);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    for (int n = 1; n < 64; n++) begin
      @(negedge clk);
      if (n == 1) reqValid = 1'b0;
      if (memCsN) break;
      csLow++;
      if (!memWeN) begin
        weLow++;
        if (firstWe < 0) firstWe = csLow - 1;
      end
      if (!memOeN) oeBad++;
      if (memDqOe != !memWeN) dqBad++;
      if (reqReady) busyBad++;
      if (memAddr != a) addrBad++;
    end
    chk(csLow == SETUP + WEC + RECOV, "R7 select length", csLow, SETUP + WEC + RECOV);
    chk(weLow == WEC, "R7 pulse length", weLow, WEC);
    chk(firstWe == SETUP, "R3 setup before strobe", firstWe, SETUP);
    chk(addrBad == 0 && busyBad == 0, "R3 address held, busy", addrBad + busyBad, 0);
    chk(oeBad == 0, "R5 output enable high", oeBad, 0);
    chk(dqBad == 0, "R6 drive matches strobe", dqBad, 0);
    chk(reqReady == 1'b1 && memCsN == 1'b1, "R4 deselect after write", int'(memCsN), 1);
    refMem[a] = d;
  endtask

  task automatic doRead(input logic [AW-1:0] a, output logic [DW-1:0] d);
    int rdLow = 0, bad = 0, seen = 0;
    @(negedge clk);
    chk(reqReady == 1'b1 && memCsN == 1'b1, "R4 idle before read", int'(reqReady), 1);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    for (int n = 1; n < 64; n++) begin
      @(negedge clk);
      if (n == 1) reqValid = 1'b0;
      if (rspValid) begin
        seen = n;
        break;
      end
      if (!memCsN) rdLow++;
      if (memCsN || memOeN || !memWeN || memDqOe || reqReady || memAddr != a) bad++;
    end
    chk(seen == ACC + 1, "R2 response latency", seen, ACC + 1);
    chk(rdLow == ACC && bad == 0, "R2 read strobes", rdLow, ACC);
    chk(memCsN == 1'b1 && reqReady == 1'b1, "R4 deselect with response", int'(memCsN), 1);
    d = rspData;
    @(negedge clk);
    chk(rspValid == 1'b0, "R2 single-cycle valid", int'(rspValid), 0);
  endtask

  function automatic logic [DW-1:0] patt(input logic [AW-1:0] a);
    return a[7:0] ^ {a[10:8], 5'b10110};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [DW-1:0] got;
    logic [31:0] lfsr;
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 8'h00;
      refMem[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(memCsN && memWeN && memOeN && !memDqOe && reqReady && !rspValid,
        "R1 state during reset", {memCsN, memWeN, memOeN, memDqOe, reqReady, rspValid}, 6'b111010);
    rstN = 1'b1;
    @(negedge clk);
    chk(memCsN && memWeN && memOeN && !memDqOe && reqReady && !rspValid,
        "R1 state after reset", {memCsN, memWeN, memOeN, memDqOe, reqReady, rspValid}, 6'b111010);

    // R8 full sweeps: pattern, then inverse
    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < DEPTH; a++) doWrite(AW'(a), pass == 0 ? patt(AW'(a)) : ~patt(AW'(a)));
      for (int a = 0; a < DEPTH; a++) begin
        doRead(AW'(a), got);
        chk(got == (pass == 0 ? patt(AW'(a)) : ~patt(AW'(a))), "R8 sweep readback",
            int'(got), int'(pass == 0 ? patt(AW'(a)) : ~patt(AW'(a))));
      end
    end

    // R8 random mixed traffic against the reference array
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 1500; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[3]) doWrite(lfsr[AW+7:8], lfsr[31:24]);
      else begin
        doRead(lfsr[AW+7:8], got);
        chk(got == refMem[lfsr[AW+7:8]], "R8 random readback", int'(got), int'(refMem[lfsr[AW+7:8]]));
      end
    end

    @(negedge clk);
    chk(addrViol == 0, "R3 model address violations", addrViol, 0);
    chk(clash == 0, "R6 model bus clashes", clash, 0);
    chk(undriven == 0, "R6 model undriven writes", undriven, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule